// File: doc/BRIEF.md
# Reset Source Controller with Software Countdown

This block collects a set of active-high reset requests from around the chip and turns them into a single registered SoC reset output. Every source can be switched on or off on its own. Each source also has its own release policy. A held source keeps the SoC in reset for as long as the request stays high. A pulsed source produces one reset of fixed width and then lets go, even if the request is still present.

Whenever a reset fires, the block records which enabled sources were active. These sticky flags survive the SoC reset and are cleared by software writing ones. A software countdown, stepped by a reference tick pulse, acts as one more reset source. The block itself is cleared only by the power-on reset input `rst`.

Software reaches all of this through a small 32-bit register port. Reads are combinational and writes take one strobe.

Top module: `rstsrc_ctrl`

## Requirements
- R1: Reading byte offset 0x04 returns the live level of each implemented source. The implemented hardware bits are 0, 4, 5, 16, 17, 24 and 30, taken from `src_in`. Bit 31 shows the software countdown request. Every other bit reads 0, including `src_in[31]`.
- R2: A source whose enable bit (offset 0x0C) is 0 neither asserts `soc_rst_o` nor sets a flag, even while it is active.
- R3: A rising edge on an enabled source sets `soc_rst_o` at the next clock edge. For a source whose hold bit is 0, the output stays high for exactly 16 `ref_tick` pulses and then drops, even if the source is still high. It fires again only after the source falls and rises again.
- R4: While an enabled source with its hold bit set (offset 0x08) is high, `soc_rst_o` stays high. It drops one clock after that source falls, provided the 16-tick minimum has elapsed.
- R5: When a reset fires, the flag register (offset 0x00) ORs in every enabled active source. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R6: After power-on reset, flags, hold and counter read 0 and enable reads 0xC1030031. Writes to unimplemented bits of flags, hold and enable are dropped, and those bits read 0.
- R7: The countdown at offset 0x1C loads on write. It then decreases by one on each `ref_tick` and stays at 0 once there.
- R8: When the countdown holds the value 2, source bit 31 is active. With bit 31 enabled, this fires a reset and sets flag bit 31.
- R9: Writing 0 to the countdown before it reaches 2 cancels the software reset: no reset output and no flag.
- R10: Writes to the status offset and to unmapped offsets such as 0x10 and 0x14 change nothing, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| ref_tick | input | 1 | One-cycle pulse per reference period |
| src_in | input | 32 | Raw reset requests, bit-mapped as in R1 |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| soc_rst_o | output | 1 | SoC reset request, active high |

## Verification
The policy logic is exercised with four patterns. A pulsed watchdog source is left high past its window, which shows that release does not depend on the source falling. A held debug source is kept up well beyond 16 ticks, which separates held release from pulsed release. A second source is raised while an old flag is still set, which distinguishes OR-accumulation from overwrite. All sources are driven high with every enable cleared, which shows that gating happens before both the output and the flags. The countdown is run through the value 2 to zero, cancelled mid-count, and parked at 2 with its enable off, which separates the request itself from its gating.

// File: rtl/rstsrc_pkg.sv
package rstsrc_pkg;

    localparam int SRC_W  = 32;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;

    typedef logic [SRC_W-1:0]  src_vec_t;
    typedef logic [DATA_W-1:0] word_t;

    // source bit positions
    localparam int B_BROWN  = 0;
    localparam int B_DBG    = 4;
    localparam int B_TAPSW  = 5;
    localparam int B_WD0    = 16;
    localparam int B_WD1    = 17;
    localparam int B_PMWD   = 24;
    localparam int B_TAPRST = 30;
    localparam int B_SW     = 31;

    localparam src_vec_t HW_MASK = (src_vec_t'(1) << B_BROWN) | (src_vec_t'(1) << B_DBG)
                                 | (src_vec_t'(1) << B_TAPSW) | (src_vec_t'(1) << B_WD0)
                                 | (src_vec_t'(1) << B_WD1)   | (src_vec_t'(1) << B_PMWD)
                                 | (src_vec_t'(1) << B_TAPRST);
    localparam src_vec_t IMPL_MASK = HW_MASK | (src_vec_t'(1) << B_SW);

    // countdown value that raises the software request
    localparam int SW_FIRE_VAL = 2;

    typedef enum logic [2:0] {
        SEL_FLAG,
        SEL_STAT,
        SEL_HOLD,
        SEL_EN,
        SEL_CNT,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic     valid;
        reg_sel_e sel;
        word_t    data;
    } bus_wr_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            5'h00:   return SEL_FLAG;
            5'h04:   return SEL_STAT;
            5'h08:   return SEL_HOLD;
            5'h0C:   return SEL_EN;
            5'h1C:   return SEL_CNT;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/rstsrc_swcnt.sv
module rstsrc_swcnt
    import rstsrc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_val,
    output logic [CNT_W-1:0] cnt_o,
    output logic             req_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (wr_en) begin
            cnt_q <= wr_val;
        end else if (ref_tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign cnt_o = cnt_q;
    assign req_o = (cnt_q == CNT_W'(SW_FIRE_VAL));
endmodule

// File: rtl/rstsrc_regs.sv
module rstsrc_regs
    import rstsrc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_wr_t  wr,
    input  src_vec_t en_live,
    input  logic     trig,
    output src_vec_t enable_o,
    output src_vec_t hold_o,
    output src_vec_t flags_o,
    output src_vec_t clr_o
);
    src_vec_t en_q, hold_q, flag_q, clr;

    assign clr = (wr.valid && wr.sel == SEL_FLAG) ? wr.data : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= IMPL_MASK;
            hold_q <= '0;
            flag_q <= '0;
        end else begin
            if (wr.valid && wr.sel == SEL_EN)   en_q   <= wr.data & IMPL_MASK;
            if (wr.valid && wr.sel == SEL_HOLD) hold_q <= wr.data & IMPL_MASK;
            // capture has priority over a same-cycle clear
            flag_q <= (flag_q & ~clr) | (trig ? (en_live & IMPL_MASK) : '0);
        end
    end

    assign enable_o = en_q;
    assign hold_o   = hold_q;
    assign flags_o  = flag_q;
    assign clr_o    = clr;
endmodule

// File: rtl/rstsrc_seq.sv
module rstsrc_seq
    import rstsrc_pkg::*;
#(
    parameter int PULSE_TICKS = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     ref_tick,
    input  src_vec_t en_live,
    input  src_vec_t hold,
    output logic     trig_o,
    output logic     soc_rst_o
);
    localparam int PW = $clog2(PULSE_TICKS + 1);

    src_vec_t        en_q, rise, held;
    logic [PW-1:0]   pcnt_q, pcnt_nx;
    logic            rst_q;

    assign rise = en_live & ~en_q;

    for (genvar g = 0; g < SRC_W; g++) begin : g_pol
        assign held[g] = en_live[g] & hold[g];
    end

    always_comb begin
        pcnt_nx = pcnt_q;
        if (|rise) begin
            pcnt_nx = PW'(PULSE_TICKS);
        end else if (ref_tick && (pcnt_q != '0)) begin
            pcnt_nx = pcnt_q - PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pcnt_q <= '0;
            rst_q  <= 1'b0;
        end else begin
            en_q   <= en_live;
            pcnt_q <= pcnt_nx;
            rst_q  <= (pcnt_nx != '0) | (|held);
        end
    end

    assign trig_o    = |rise;
    assign soc_rst_o = rst_q;
endmodule

// File: rtl/rstsrc_ctrl.sv
module rstsrc_ctrl
    import rstsrc_pkg::*;
#(
    parameter int PULSE_TICKS = 16,
    parameter int CNT_W       = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ref_tick,
    input  logic [SRC_W-1:0]     src_in,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 soc_rst_o
);
    bus_wr_t          wreq;
    reg_sel_e         sel;
    src_vec_t         live, en_live, en_q, hold_q, flags_q, flag_clr;
    logic [CNT_W-1:0] cnt;
    logic             sw_req, trig, cnt_wr;

    assign sel  = decode_addr(bus_addr);
    assign wreq = '{valid: bus_wr, sel: sel, data: bus_wdata};
    assign cnt_wr = bus_wr && (sel == SEL_CNT);

    rstsrc_swcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .ref_tick (ref_tick),
        .wr_en    (cnt_wr),
        .wr_val   (bus_wdata[CNT_W-1:0]),
        .cnt_o    (cnt),
        .req_o    (sw_req)
    );

    assign live    = (src_in & HW_MASK) | (src_vec_t'(sw_req) << B_SW);
    assign en_live = live & en_q;

    rstsrc_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (wreq),
        .en_live  (en_live),
        .trig     (trig),
        .enable_o (en_q),
        .hold_o   (hold_q),
        .flags_o  (flags_q),
        .clr_o    (flag_clr)
    );

    rstsrc_seq #(.PULSE_TICKS(PULSE_TICKS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .ref_tick  (ref_tick),
        .en_live   (en_live),
        .hold      (hold_q),
        .trig_o    (trig),
        .soc_rst_o (soc_rst_o)
    );

    always_comb begin
        case (sel)
            SEL_FLAG: bus_rdata = flags_q;
            SEL_STAT: bus_rdata = live;
            SEL_HOLD: bus_rdata = hold_q;
            SEL_EN:   bus_rdata = en_q;
            SEL_CNT:  bus_rdata = DATA_W'(cnt);
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rstsrc_ctrl_chk.sv
module rstsrc_ctrl_chk
    import rstsrc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             ref_tick,
    input logic             trig,
    input src_vec_t         en_live,
    input src_vec_t         hold_q,
    input src_vec_t         flags_q,
    input src_vec_t         flag_clr,
    input logic [CNT_W-1:0] cnt,
    input logic             cnt_wr,
    input logic             soc_rst_o
);
    // R3: an enabled rising source raises the output next cycle
    p_trig_rst_r3: assert property (@(posedge clk) disable iff (rst)
        trig |=> soc_rst_o);

    // R4: an active held source keeps the output high
    p_hold_rst_r4: assert property (@(posedge clk) disable iff (rst)
        (|(en_live & hold_q)) |=> soc_rst_o);

    // R5: flags only drop through a write-one clear
    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (flag_clr == '0) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R7: countdown rests at zero
    p_cnt_floor_r7: assert property (@(posedge clk) disable iff (rst)
        ((cnt == '0) && !cnt_wr) |=> (cnt == '0));

    // R7: one step per tick
    p_cnt_step_r7: assert property (@(posedge clk) disable iff (rst)
        (ref_tick && (cnt != '0) && !cnt_wr) |=> (cnt == ($past(cnt) - CNT_W'(1))));
endmodule

bind rstsrc_ctrl rstsrc_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ref_tick  (ref_tick),
    .trig      (trig),
    .en_live   (en_live),
    .hold_q    (hold_q),
    .flags_q   (flags_q),
    .flag_clr  (flag_clr),
    .cnt       (cnt),
    .cnt_wr    (cnt_wr),
    .soc_rst_o (soc_rst_o)
);

// File: tb/rstsrc_ctrl_test.sv
module rstsrc_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_tick = 1'b0;
    logic [31:0] src_in = '0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        soc_rst_o;

    always #10 clk = ~clk;

    rstsrc_ctrl uut (
        .clk       (clk),
        .rst       (rst),
        .ref_tick  (ref_tick),
        .src_in    (src_in),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .soc_rst_o (soc_rst_o)
    );

    localparam logic [4:0] A_FLAG = 5'h00, A_STAT = 5'h04, A_HOLD = 5'h08,
                           A_EN = 5'h0C, A_CNT = 5'h1C;
    localparam logic [31:0] IMPL = 32'hC103_0031;
    localparam logic [31:0] HWM  = 32'h4103_0031;

    int n_chk = 0;
    int n_err = 0;

    typedef struct {
        string       req;
        logic [31:0] exp;
    } exp_t;
    exp_t sb_q[$];

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            ref_tick = 1'b1;
            @(negedge clk);
            ref_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    // driver side: queue an expectation
    task automatic push_exp(input string req, input logic [31:0] e);
        sb_q.push_back('{req, e});
    endtask

    // monitor side: pop and compare
    task automatic mon_cmp(input logic [31:0] act);
        exp_t it;
        n_chk++;
        if (sb_q.size() == 0) begin
            n_err++;
            $display("FAIL scoreboard empty: actual=%h expected=none", act);
        end else begin
            it = sb_q.pop_front();
            if (act !== it.exp) begin
                n_err++;
                $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
            end
        end
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] e);
        push_exp(req, e);
        bus_addr = a;
        #1;
        mon_cmp(bus_rdata);
    endtask

    task automatic rst_chk(input string req, input logic e);
        push_exp(req, {31'b0, e});
        #1;
        mon_cmp({31'b0, soc_rst_o});
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R6 reset state, R1 quiet status
        rst_chk("R6 output after por", 1'b0);
        rd_chk("R6 flags after por", A_FLAG, 32'h0);
        rd_chk("R6 hold after por", A_HOLD, 32'h0);
        rd_chk("R6 enable after por", A_EN, IMPL);
        rd_chk("R6 counter after por", A_CNT, 32'h0);
        rd_chk("R1 status idle", A_STAT, 32'h0);

        // R2: all sources high, all disabled
        bus_write(A_EN, 32'h0);
        src_in = 32'hFFFF_FFFF;
        cyc(3);
        rd_chk("R1 status all high", A_STAT, HWM);
        rst_chk("R2 disabled sources no reset", 1'b0);
        rd_chk("R2 disabled sources no flag", A_FLAG, 32'h0);
        src_in = '0;
        cyc(2);

        // R6 unimplemented bits dropped
        bus_write(A_EN, 32'hFFFF_FFFF);
        rd_chk("R6 enable masking", A_EN, IMPL);
        bus_write(A_HOLD, 32'hFFFF_FFFF);
        rd_chk("R6 hold masking", A_HOLD, IMPL);
        bus_write(A_HOLD, 32'h0000_0010);
        rd_chk("R6 hold debug only", A_HOLD, 32'h0000_0010);

        // R10 status and unmapped writes ignored
        bus_write(A_STAT, 32'hFFFF_FFFF);
        bus_write(5'h14, 32'hFFFF_FFFF);
        rd_chk("R10 status unchanged", A_STAT, 32'h0);
        rd_chk("R10 unmapped 0x14 reads 0", 5'h14, 32'h0);
        rd_chk("R10 unmapped 0x10 reads 0", 5'h10, 32'h0);
        rd_chk("R10 enable untouched", A_EN, IMPL);
        rst_chk("R10 no reset from writes", 1'b0);

        // R3 pulsed watchdog 0
        src_in = 32'h0001_0000;
        cyc(1);
        rst_chk("R3 asserted after edge", 1'b1);
        rd_chk("R5 flag wd0", A_FLAG, 32'h0001_0000);
        tick(15);
        rst_chk("R3 high at tick 15", 1'b1);
        tick(1);
        rst_chk("R3 released at tick 16 with source high", 1'b0);
        tick(3);
        rst_chk("R3 no retrigger while high", 1'b0);
        src_in = '0;
        cyc(2);
        src_in = 32'h0001_0000;
        cyc(1);
        rst_chk("R3 retrigger on new edge", 1'b1);
        tick(16);
        rst_chk("R3 second pulse ends", 1'b0);
        src_in = '0;
        cyc(1);

        // R5 write-one clear
        bus_write(A_FLAG, 32'h0);
        rd_chk("R5 write zero keeps flag", A_FLAG, 32'h0001_0000);
        bus_write(A_FLAG, 32'h0001_0000);
        rd_chk("R5 write one clears", A_FLAG, 32'h0);

        // R4 held debug source
        src_in = 32'h0000_0010;
        cyc(1);
        rst_chk("R4 held asserted", 1'b1);
        tick(20);
        rst_chk("R4 held past pulse width", 1'b1);
        src_in = '0;
        cyc(1);
        rst_chk("R4 released after source falls", 1'b0);
        rd_chk("R5 flag debug", A_FLAG, 32'h0000_0010);

        // R5 accumulation
        src_in = 32'h0000_0001;
        cyc(1);
        rd_chk("R5 flags accumulate", A_FLAG, 32'h0000_0011);
        tick(16);
        src_in = '0;
        cyc(1);
        bus_write(A_FLAG, 32'hFFFF_FFFF);
        rd_chk("R5 clear all", A_FLAG, 32'h0);
        rst_chk("R3 idle before countdown", 1'b0);

        // R7 / R8 countdown
        bus_write(A_CNT, 32'd5);
        rd_chk("R7 counter loaded", A_CNT, 32'd5);
        tick(1);
        rd_chk("R7 counter step", A_CNT, 32'd4);
        tick(2);
        rd_chk("R8 status bit 31 at two", A_STAT, 32'h8000_0000);
        rst_chk("R8 software reset fired", 1'b1);
        rd_chk("R8 flag bit 31", A_FLAG, 32'h8000_0000);
        tick(15);
        rd_chk("R7 counter floor", A_CNT, 32'd0);
        rst_chk("R8 pulse still high", 1'b1);
        tick(1);
        rst_chk("R8 pulse ended", 1'b0);
        rd_chk("R7 counter stays zero", A_CNT, 32'd0);
        bus_write(A_FLAG, 32'hFFFF_FFFF);

        // R9 cancel
        bus_write(A_CNT, 32'd4);
        tick(1);
        bus_write(A_CNT, 32'd0);
        rd_chk("R9 cancelled counter", A_CNT, 32'd0);
        tick(5);
        rst_chk("R9 no reset after cancel", 1'b0);
        rd_chk("R9 no flag after cancel", A_FLAG, 32'h0);

        // R2 software source disabled
        bus_write(A_EN, HWM);
        bus_write(A_CNT, 32'd2);
        cyc(3);
        rd_chk("R2 sw request visible", A_STAT, 32'h8000_0000);
        rst_chk("R2 sw disabled no reset", 1'b0);
        rd_chk("R2 sw disabled no flag", A_FLAG, 32'h0);

        if (sb_q.size() != 0) begin
            n_err += sb_q.size();
            $display("FAIL scoreboard leftover: actual=%0d expected=0", sb_q.size());
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog all: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule